// File: doc/BRIEF.md
# Stream-to-Video Lock Bridge

The bridge takes a pixel stream framed in the AXI4-Stream manner and puts it onto a raster video output. On the stream, TUSER marks the first pixel of a frame and TLAST marks the last pixel of a line. The raster timing comes from an external timing generator that runs freely and that the bridge never stalls. It supplies vertical and horizontal sync, vertical and horizontal blanking, and an active-video strobe. The stream and the raster share one clock. The stream side follows the raster through TREADY back-pressure.

An input FIFO, 2048 entries deep by default, decouples the two sides. A lock state machine aligns the stream's frame start with the raster's frame. It passes through four states:

- It waits for a falling edge on vertical sync or vertical blanking.
- It discards stream beats until it finds a start-of-frame beat.
- It parks that beat until the next vertical sync.
- It runs, emitting one stored pixel per active-video cycle.

While running, the bridge compares the stream's line and frame structure against the raster. Any disagreement drops lock and restarts acquisition. Status outputs report lock, FIFO underflow during active video (sticky) and length errors (sticky). The default raster is 1280x720 active pixels at 60 frames per second.

Top module: `svlb_bridge`

## Requirements
- R1: After reset, and after any loss of lock, the bridge waits for a falling edge on `t_vsync` or `t_vblank`. Until that edge `s_tready` stays 0, no beat is accepted and `locked` is 0.
- R2: After that edge the bridge accepts beats and drops every beat whose `s_tuser` is 0, until a beat with `s_tuser` = 1 arrives. That start-of-frame beat is the first pixel shown once locked.
- R3: Once the start-of-frame beat is held, `s_tready` stays 0 until a rising edge of `t_vsync`. `locked` reads 1 in the cycle after the rising edge is sampled.
- R4: While locked, each cycle with `t_active` = 1 takes one stored beat. `v_data` shows the beats in stream order one cycle later. `v_vsync`, `v_hsync`, `v_vblank`, `v_hblank` and `v_active` equal the timing inputs delayed by one cycle.
- R5: In every cycle where `v_active` is 0, `v_data` is 0.
- R6: If the FIFO is empty in a locked active cycle, `v_data` shows `BLANK_PIX` one cycle later and `err_underflow` sets and stays set. Lock is kept.
- R7: While locked, `s_tlast` must be 1 exactly on the beat at active column `ACT_W-1` of each line. A beat that breaks this rule, whether the line is too short or too long, sets `err_length`, drops `locked` and restarts at R1.
- R8: While locked, `s_tuser` must be 1 exactly on the beat at row 0, column 0. A start-of-frame beat that arrives early, or a row-0/column-0 beat without it, sets `err_length`, drops `locked`, and the bridge then reacquires lock by R1 to R3.
- R9: `s_tready` is 1 only when the FIFO is not full and the bridge is in the discard or locked state. Accepted beats are never lost, and up to `FIFO_DEPTH` beats are buffered.
- R10: A one-cycle pulse on `clr_sticky` clears `err_underflow` and `err_length`. Neither flag clears in any other way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared stream and pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_sticky | input | 1 | Clears the sticky error flags |
| s_tdata | input | PIX_W | Stream pixel |
| s_tvalid | input | 1 | Stream beat valid |
| s_tready | output | 1 | Stream beat accepted |
| s_tuser | input | 1 | Start-of-frame marker |
| s_tlast | input | 1 | End-of-line marker |
| t_vsync | input | 1 | Vertical sync from the timing generator |
| t_hsync | input | 1 | Horizontal sync from the timing generator |
| t_vblank | input | 1 | Vertical blanking from the timing generator |
| t_hblank | input | 1 | Horizontal blanking from the timing generator |
| t_active | input | 1 | Active-video strobe from the timing generator |
| v_data | output | PIX_W | Output pixel |
| v_vsync | output | 1 | Delayed vertical sync |
| v_hsync | output | 1 | Delayed horizontal sync |
| v_vblank | output | 1 | Delayed vertical blanking |
| v_hblank | output | 1 | Delayed horizontal blanking |
| v_active | output | 1 | Delayed active video |
| locked | output | 1 | Stream aligned to the raster |
| err_underflow | output | 1 | Sticky: FIFO empty during locked active video |
| err_length | output | 1 | Sticky: line or frame structure mismatch |

## Verification
The bound checker watches, on every cycle, the cycle-level invariants:

- TREADY stays low while waiting for the edge and while holding the start-of-frame beat.
- TREADY is gated by FIFO fullness and state.
- Lock rises only right after a vsync rising edge.
- The timing outputs carry a one-cycle delay.
- The pixel is zero outside active video.
- An underflow shows the blank value.
- A length error is never reported while locked.

The bench's scenarios cover the end-to-end behaviour that needs a whole frame of history:

- Junk before the first start-of-frame beat is discarded.
- Pixel order holds across several frames with the FIFO running full.
- Short lines, long lines and truncated frames are detected.
- Lock is regained after a drop.
- The sticky flags clear.

// File: rtl/svlb_pkg.sv
package svlb_pkg;

    typedef enum logic [1:0] {
        LK_WAIT  = 2'd0,
        LK_FLUSH = 2'd1,
        LK_HOLD  = 2'd2,
        LK_RUN   = 2'd3
    } lock_state_e;

    typedef struct packed {
        logic sof;
        logic eol;
    } beat_tag_t;

    typedef struct packed {
        logic vsync;
        logic hsync;
        logic vblank;
        logic hblank;
        logic active;
    } raster_t;

    localparam int TAG_W = $bits(beat_tag_t);

    function automatic int ptr_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/svlb_fifo.sv
module svlb_fifo #(
    parameter int WIDTH = 26,
    parameter int DEPTH = 2048
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    import svlb_pkg::*;

    localparam int AW = ptr_bits(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [AW:0]      count;
    logic             do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign empty   = (count == '0);
    assign full    = (count == (AW+1)'(DEPTH));
    assign head    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wr_data;
    end

endmodule

// File: rtl/svlb_lock_ctrl.sv
module svlb_lock_ctrl #(
    parameter int ACT_W = 1280,
    parameter int ACT_H = 720
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  t_vsync,
    input  logic                  t_vblank,
    input  logic                  t_active,
    input  logic                  fifo_empty,
    input  svlb_pkg::beat_tag_t   head_tag,
    output svlb_pkg::lock_state_e state,
    output logic                  pop,
    output logic                  fifo_clr,
    output logic                  accept_en,
    output logic                  underrun,
    output logic                  mismatch
);
    import svlb_pkg::*;

    localparam int CW = ptr_bits(ACT_W);
    localparam int RW = ptr_bits(ACT_H);

    lock_state_e   nxt;
    logic          vs_q, vb_q;
    logic          fall_edge, vs_rise;
    logic [CW-1:0] col;
    logic [RW-1:0] row;
    logic          want_sof, want_eol;

    assign fall_edge = (vs_q && !t_vsync) || (vb_q && !t_vblank);
    assign vs_rise   = t_vsync && !vs_q;
    assign want_sof  = (col == '0) && (row == '0);
    assign want_eol  = (col == CW'(ACT_W - 1));
    assign accept_en = (state == LK_FLUSH) || (state == LK_RUN);
    assign fifo_clr  = (state == LK_WAIT);

    always_comb begin
        nxt      = state;
        pop      = 1'b0;
        underrun = 1'b0;
        mismatch = 1'b0;
        case (state)
            LK_WAIT: begin
                if (fall_edge) nxt = LK_FLUSH;
            end
            LK_FLUSH: begin
                if (!fifo_empty) begin
                    if (head_tag.sof) nxt = LK_HOLD;
                    else              pop = 1'b1;
                end
            end
            LK_HOLD: begin
                if (vs_rise) nxt = LK_RUN;
            end
            LK_RUN: begin
                if (t_active) begin
                    if (fifo_empty) begin
                        underrun = 1'b1;
                    end else begin
                        pop = 1'b1;
                        if ((head_tag.sof != want_sof) || (head_tag.eol != want_eol)) begin
                            mismatch = 1'b1;
                            nxt      = LK_WAIT;
                        end
                    end
                end
            end
            default: nxt = LK_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LK_WAIT;
            vs_q  <= 1'b0;
            vb_q  <= 1'b0;
            col   <= '0;
            row   <= '0;
        end else begin
            state <= nxt;
            vs_q  <= t_vsync;
            vb_q  <= t_vblank;
            if (state != LK_RUN) begin
                col <= '0;
                row <= '0;
            end else if (t_active) begin
                if (want_eol) begin
                    col <= '0;
                    row <= (row == RW'(ACT_H - 1)) ? '0 : row + 1'b1;
                end else begin
                    col <= col + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/svlb_out_stage.sv
module svlb_out_stage #(
    parameter int               PIX_W     = 24,
    parameter logic [PIX_W-1:0] BLANK_PIX = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  svlb_pkg::raster_t  tim_in,
    input  logic               show,
    input  logic               use_blank,
    input  logic [PIX_W-1:0]   pix_in,
    output svlb_pkg::raster_t  tim_out,
    output logic [PIX_W-1:0]   pix_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tim_out <= '0;
            pix_out <= '0;
        end else begin
            tim_out <= tim_in;
            if (!show)          pix_out <= '0;
            else if (use_blank) pix_out <= BLANK_PIX;
            else                pix_out <= pix_in;
        end
    end
endmodule

// File: rtl/svlb_bridge.sv
module svlb_bridge #(
    parameter int               PIX_W      = 24,
    parameter int               FIFO_DEPTH = 2048,
    parameter int               ACT_W      = 1280,
    parameter int               ACT_H      = 720,
    parameter logic [PIX_W-1:0] BLANK_PIX  = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_sticky,
    input  logic [PIX_W-1:0] s_tdata,
    input  logic             s_tvalid,
    output logic             s_tready,
    input  logic             s_tuser,
    input  logic             s_tlast,
    input  logic             t_vsync,
    input  logic             t_hsync,
    input  logic             t_vblank,
    input  logic             t_hblank,
    input  logic             t_active,
    output logic [PIX_W-1:0] v_data,
    output logic             v_vsync,
    output logic             v_hsync,
    output logic             v_vblank,
    output logic             v_hblank,
    output logic             v_active,
    output logic             locked,
    output logic             err_underflow,
    output logic             err_length
);
    import svlb_pkg::*;

    localparam int FW = PIX_W + TAG_W;

    lock_state_e      lock_st;
    logic             fifo_full, fifo_empty, fifo_pop, fifo_clr;
    logic             accept_en, underrun, mismatch;
    logic [FW-1:0]    fifo_head;
    beat_tag_t        head_tag, in_tag;
    logic [PIX_W-1:0] head_pix;
    raster_t          tim_in, tim_out;

    assign in_tag.sof = s_tuser;
    assign in_tag.eol = s_tlast;
    assign head_tag   = beat_tag_t'(fifo_head[FW-1:PIX_W]);
    assign head_pix   = fifo_head[PIX_W-1:0];
    assign s_tready   = accept_en && !fifo_full;
    assign locked     = (lock_st == LK_RUN);

    svlb_fifo #(.WIDTH(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .clr     (fifo_clr),
        .push    (s_tvalid && s_tready),
        .wr_data ({in_tag, s_tdata}),
        .pop     (fifo_pop),
        .head    (fifo_head),
        .empty   (fifo_empty),
        .full    (fifo_full)
    );

    svlb_lock_ctrl #(.ACT_W(ACT_W), .ACT_H(ACT_H)) u_lock (
        .clk        (clk),
        .rst        (rst),
        .t_vsync    (t_vsync),
        .t_vblank   (t_vblank),
        .t_active   (t_active),
        .fifo_empty (fifo_empty),
        .head_tag   (head_tag),
        .state      (lock_st),
        .pop        (fifo_pop),
        .fifo_clr   (fifo_clr),
        .accept_en  (accept_en),
        .underrun   (underrun),
        .mismatch   (mismatch)
    );

    assign tim_in = '{vsync: t_vsync, hsync: t_hsync, vblank: t_vblank,
                      hblank: t_hblank, active: t_active};

    svlb_out_stage #(.PIX_W(PIX_W), .BLANK_PIX(BLANK_PIX)) u_out (
        .clk       (clk),
        .rst       (rst),
        .tim_in    (tim_in),
        .show      (locked && t_active),
        .use_blank (fifo_empty),
        .pix_in    (head_pix),
        .tim_out   (tim_out),
        .pix_out   (v_data)
    );

    assign v_vsync  = tim_out.vsync;
    assign v_hsync  = tim_out.hsync;
    assign v_vblank = tim_out.vblank;
    assign v_hblank = tim_out.hblank;
    assign v_active = tim_out.active;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_underflow <= 1'b0;
            err_length    <= 1'b0;
        end else begin
            if (clr_sticky) begin
                err_underflow <= 1'b0;
                err_length    <= 1'b0;
            end
            if (underrun) err_underflow <= 1'b1;
            if (mismatch) err_length    <= 1'b1;
        end
    end

endmodule

// File: rtl/svlb_checker.sv
module svlb_checker #(
    parameter int               PIX_W     = 24,
    parameter logic [PIX_W-1:0] BLANK_PIX = '0
) (
    input logic                  clk,
    input logic                  rst,
    input svlb_pkg::lock_state_e st,
    input logic                  s_tready,
    input logic                  fifo_full,
    input logic                  t_vsync,
    input logic                  t_hsync,
    input logic                  t_active,
    input logic                  v_vsync,
    input logic                  v_hsync,
    input logic                  v_active,
    input logic [PIX_W-1:0]      v_data,
    input logic                  locked,
    input logic                  err_underflow,
    input logic                  err_length
);
    import svlb_pkg::*;

    assert_wait_no_ready_R1: assert property (@(posedge clk) disable iff (rst)
        (st == LK_WAIT) |-> !s_tready);

    assert_hold_no_ready_R3: assert property (@(posedge clk) disable iff (rst)
        (st == LK_HOLD) |-> !s_tready);

    assert_lock_after_vsync_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> ($past(t_vsync) && !$past(t_vsync, 2)));

    assert_timing_delay_R4: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ({v_vsync, v_hsync, v_active} == $past({t_vsync, t_hsync, t_active})));

    assert_zero_outside_R5: assert property (@(posedge clk) disable iff (rst)
        !v_active |-> (v_data == '0));

    assert_underflow_blank_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(err_underflow) |-> ((v_data == BLANK_PIX) && $past(locked)));

    assert_len_err_unlocks_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(err_length) |-> !locked);

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        s_tready |-> (!fifo_full && (st == LK_FLUSH || st == LK_RUN)));

endmodule

bind svlb_bridge svlb_checker #(.PIX_W(PIX_W), .BLANK_PIX(BLANK_PIX)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .st            (lock_st),
    .s_tready      (s_tready),
    .fifo_full     (fifo_full),
    .t_vsync       (t_vsync),
    .t_hsync       (t_hsync),
    .t_active      (t_active),
    .v_vsync       (v_vsync),
    .v_hsync       (v_hsync),
    .v_active      (v_active),
    .v_data        (v_data),
    .locked        (locked),
    .err_underflow (err_underflow),
    .err_length    (err_length)
);

// File: tb/svlb_bridge_test.sv
module svlb_bridge_test;
    localparam int DW = 16;
    localparam int DEPTH = 64;
    localparam int AW_ = 8;
    localparam int AH = 4;
    localparam int HT = 12;
    localparam int VT = 7;
    localparam logic [DW-1:0] BLK = 16'hBEEF;

    logic clk = 1'b0, rst = 1'b1, clr_sticky = 1'b0;
    logic [DW-1:0] s_tdata = '0;
    logic s_tvalid = 1'b0, s_tuser = 1'b0, s_tlast = 1'b0, s_tready;
    logic t_vsync = 1'b0, t_hsync = 1'b0, t_vblank = 1'b0, t_hblank = 1'b0, t_active = 1'b0;
    logic [DW-1:0] v_data;
    logic v_vsync, v_hsync, v_vblank, v_hblank, v_active, locked, err_underflow, err_length;

    always #2 clk = ~clk;

    svlb_bridge #(.PIX_W(DW), .FIFO_DEPTH(DEPTH), .ACT_W(AW_), .ACT_H(AH), .BLANK_PIX(BLK)) uut (
        .clk(clk), .rst(rst), .clr_sticky(clr_sticky),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .s_tuser(s_tuser), .s_tlast(s_tlast),
        .t_vsync(t_vsync), .t_hsync(t_hsync), .t_vblank(t_vblank),
        .t_hblank(t_hblank), .t_active(t_active),
        .v_data(v_data), .v_vsync(v_vsync), .v_hsync(v_hsync), .v_vblank(v_vblank),
        .v_hblank(v_hblank), .v_active(v_active), .locked(locked),
        .err_underflow(err_underflow), .err_length(err_length)
    );

    int errors = 0, checks = 0;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // beat store
    logic [DW-1:0] bdat [1024];
    bit bsof [1024];
    bit beol [1024];
    int nb = 0, sidx = 0, acc = 0, max_occ = 0;
    bit took = 1'b0;

    // monitor state
    int gh = 0, gv = 0, since_rst = 0;
    bit edge_seen = 1'b0, mon_en = 1'b0, lock_prev = 1'b0, lock_vs = 1'b0;
    int exp_idx = 0, mon_lim = 0, pix_cmp = 0, pix_bad = 0, zero_bad = 0, tim_bad = 0, pre_ready = 0;
    logic [DW-1:0] first_pix = '0;

    // stream source
    initial begin
        forever begin
            @(negedge clk);
            if (rst) begin
                sidx = 0; took = 1'b0; acc = 0; max_occ = 0;
            end else if (took) begin
                sidx++;
            end
            if (!rst && sidx < nb) begin
                s_tvalid = 1'b1; s_tdata = bdat[sidx]; s_tuser = bsof[sidx]; s_tlast = beol[sidx];
            end else begin
                s_tvalid = 1'b0; s_tuser = 1'b0; s_tlast = 1'b0;
            end
            took = s_tvalid && s_tready;
            if (took) acc++;
            if (mon_en && (acc - exp_idx + pix_cmp - pix_cmp - (exp_idx - 5 - pix_cmp)) > max_occ)
                max_occ = acc - 5 - pix_cmp;
        end
    end

    // raster generator and output monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst) begin
                since_rst = 0; gh = 0; gv = 0; lock_prev = 1'b0;
            end else begin
                since_rst++;
                if (since_rst >= 2) begin
                    if ({v_vsync, v_hsync, v_vblank, v_hblank, v_active} !=
                        {t_vsync, t_hsync, t_vblank, t_hblank, t_active}) tim_bad++;
                    if (!v_active && v_data != '0) zero_bad++;
                    if (!edge_seen && s_tready) pre_ready++;
                    if (locked && !lock_prev) lock_vs = t_vsync;
                    lock_prev = locked;
                    if (mon_en && locked && v_active && pix_cmp < mon_lim) begin
                        if (pix_cmp == 0) first_pix = v_data;
                        if (v_data != bdat[exp_idx]) pix_bad++;
                        exp_idx++;
                        pix_cmp++;
                    end
                end
                gh++;
                if (gh == HT) begin
                    gh = 0;
                    gv = (gv == VT - 1) ? 0 : gv + 1;
                end
            end
            begin
                logic nvs, nvb;
                nvs = (gv == 5);
                nvb = (gv >= AH);
                if (!rst && ((t_vsync && !nvs) || (t_vblank && !nvb))) edge_seen = 1'b1;
                t_vsync  = nvs;
                t_vblank = nvb;
                t_hsync  = (gh == 9) || (gh == 10);
                t_hblank = (gh >= AW_);
                t_active = (gh < AW_) && (gv < AH);
            end
        end
    end

    function automatic void add_beat(input logic [DW-1:0] d, input bit s, input bit e);
        bdat[nb] = d; bsof[nb] = s; beol[nb] = e; nb++;
    endfunction

    // kind: 0 normal, 1 short line, 2 long line at bad_row
    function automatic void add_frame(input int tag, input int rows, input int bad_row, input int kind);
        for (int r = 0; r < rows; r++) begin
            int len;
            len = (r == bad_row) ? ((kind == 1) ? AW_ - 1 : AW_ + 1) : AW_;
            for (int c = 0; c < len; c++)
                add_beat(DW'((tag << 12) | (r << 8) | c), (r == 0) && (c == 0), c == len - 1);
        end
    endfunction

    task automatic start_reset();
        rst = 1'b1; nb = 0; mon_en = 1'b0; clr_sticky = 1'b0;
        repeat (3) @(negedge clk);
        edge_seen = 1'b0; exp_idx = 0; pix_cmp = 0; pix_bad = 0; zero_bad = 0;
        tim_bad = 0; pre_ready = 0; lock_vs = 1'b0; first_pix = '0;
    endtask

    task automatic release_reset();
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic bit cond(input int kind);
        case (kind)
            0: return locked;
            1: return err_length;
            2: return v_active && locked;
            3: return v_vblank;
            4: return pix_cmp >= mon_lim;
            default: return 1'b0;
        endcase
    endfunction

    task automatic wait_for(input int kind, input int limit, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (cond(kind)) begin ok = 1'b1; break; end
        end
    endtask

    task automatic t_reset();
        start_reset();
        release_reset();
        @(negedge clk);
        check(s_tready == 1'b0, "R1", "tready after reset", s_tready, 0);
        check(locked == 1'b0, "R1", "locked after reset", locked, 0);
        check(!err_underflow && !err_length, "R10", "flags after reset", {err_underflow, err_length}, 0);
        check(v_data == '0, "R5", "pixel after reset", v_data, 0);
        repeat (30) @(negedge clk);
        check(s_tready == 1'b0 && pre_ready == 0, "R1", "tready before falling edge", pre_ready, 0);
    endtask

    task automatic t_acquire_run_underflow();
        bit ok;
        start_reset();
        for (int i = 0; i < 5; i++) add_beat(DW'(16'h0A00 + i), 1'b0, 1'b0);
        for (int f = 0; f < 4; f++) add_frame(f, AH, -1, 0);
        exp_idx = 5; mon_lim = 4 * AW_ * AH; mon_en = 1'b1;
        release_reset();
        wait_for(0, 2000, ok);
        check(ok, "R3", "lock acquired", ok, 1);
        check(lock_vs == 1'b1, "R3", "lock follows vsync rise", lock_vs, 1);
        check(pre_ready == 0, "R1", "no accept before edge", pre_ready, 0);
        wait_for(4, 3000, ok);
        check(ok, "R4", "all pixels shown", pix_cmp, mon_lim);
        check(pix_bad == 0, "R4", "pixel order mismatches", pix_bad, 0);
        check(first_pix == bdat[5], "R2", "first pixel is start-of-frame beat", first_pix, bdat[5]);
        check(tim_bad == 0, "R4", "timing delay mismatches", tim_bad, 0);
        check(zero_bad == 0, "R5", "nonzero pixel outside active", zero_bad, 0);
        check(max_occ >= DEPTH - 1 && max_occ <= DEPTH + 1, "R9", "buffer fill level", max_occ, DEPTH);
        check(err_length == 1'b0, "R7", "no length error on good frames", err_length, 0);
        mon_en = 1'b0;
        wait_for(3, 500, ok);
        wait_for(2, 500, ok);
        check(ok && v_data == BLK, "R6", "blank pixel on underflow", v_data, BLK);
        check(err_underflow == 1'b1, "R6", "underflow flag", err_underflow, 1);
        check(locked == 1'b1, "R6", "lock kept on underflow", locked, 1);
        wait_for(3, 500, ok);
        clr_sticky = 1'b1;
        @(negedge clk);
        clr_sticky = 1'b0;
        check(err_underflow == 1'b0, "R10", "underflow cleared", err_underflow, 0);
        wait_for(2, 500, ok);
        check(err_underflow == 1'b1, "R6", "underflow sets again", err_underflow, 1);
    endtask

    task automatic t_short_line();
        bit ok;
        start_reset();
        add_frame(0, AH, -1, 0);
        add_frame(1, AH, 1, 1);
        for (int f = 2; f < 6; f++) add_frame(f, AH, -1, 0);
        release_reset();
        wait_for(1, 3000, ok);
        check(ok, "R7", "short line flagged", err_length, 1);
        check(locked == 1'b0, "R7", "lock dropped on short line", locked, 0);
        @(negedge clk);
        check(s_tready == 1'b0, "R7", "restart waits with tready low", s_tready, 0);
        wait_for(0, 3000, ok);
        check(ok, "R7", "lock regained after short line", locked, 1);
        check(err_length == 1'b1, "R10", "length flag sticky", err_length, 1);
    endtask

    task automatic t_long_line();
        bit ok;
        start_reset();
        add_frame(0, AH, -1, 0);
        add_frame(1, AH, 2, 2);
        for (int f = 2; f < 5; f++) add_frame(f, AH, -1, 0);
        release_reset();
        wait_for(1, 3000, ok);
        check(ok, "R7", "long line flagged", err_length, 1);
        check(locked == 1'b0, "R7", "lock dropped on long line", locked, 0);
    endtask

    task automatic t_early_sof();
        bit ok;
        start_reset();
        add_frame(0, AH, -1, 0);
        add_frame(1, 2, -1, 0);
        for (int f = 2; f < 6; f++) add_frame(f, AH, -1, 0);
        release_reset();
        wait_for(1, 3000, ok);
        check(ok, "R8", "early start-of-frame flagged", err_length, 1);
        check(locked == 1'b0, "R8", "lock dropped on early start-of-frame", locked, 0);
        wait_for(0, 3000, ok);
        check(ok, "R8", "lock regained after early start-of-frame", locked, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_acquire_run_underflow();
        t_short_line();
        t_long_line();
        t_early_sof();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule